// File: doc/BRIEF.md
# Adaptive Cost-Aware Victim Selector

This block picks the way to evict from a 16-way cache set. It can rank ways by recency alone, as plain LRU does, or by a linear score that adds a weighted 3-bit miss cost to each way's recency. Blocks that cost more to fetch again are then kept longer. A single global selector counter decides which ranking applies to most sets. That counter learns only from a small group of leader sets, which the main directory always manages with the cost-aware ranking. A shadow LRU directory exists only for those leader sets.

Victim requests come in on a valid/ready stream that carries the set index, the per-way recency fields and the per-way costs. Each answer goes out one cycle after its request is accepted, on a second valid/ready stream, together with the ranking that produced it. A response that the consumer has not taken stays registered and unchanged. While it waits, the block takes no new request: `req_ready` is high only when the output slot is empty or is being emptied in the same cycle.

Training outcomes arrive on plain control pins, at most one per cycle: the set index, the hit or miss result in each directory, and the cost of the miss. The tag arrays and the cost measurement stay outside the block.

Top module: `sbar_selector`

## Requirements
- R1: In LRU mode the victim is the way with the smallest recency field. Way i's recency sits in `req_recency[4i+3:4i]`, and 0 means least recently used. A tie goes to the lowest way number.
- R2: In cost-aware mode the victim is the way with the smallest recency(i) + WEIGHT × cost(i), where WEIGHT defaults to 2. Way i's cost sits in `req_cost[3i+2:3i]`. A tie goes to the lowest way number.
- R3: A set is a leader set when index bits [4:0] equal index bits [9:5]. This gives 32 leader sets out of 1024.
- R4: A request for a leader set is always answered in cost-aware mode (`rsp_policy` = 1), whatever the selector holds.
- R5: A request for a follower set uses cost-aware mode when selector bit 9 is 1 and LRU mode (`rsp_policy` = 0) when it is 0. The selector resets to 512, so followers start in cost-aware mode.
- R6: A leader training event with a main hit and an auxiliary miss raises the selector by `trn_cost`.
- R7: A leader training event with a main miss and an auxiliary hit lowers the selector by `trn_cost`.
- R8: Training events in which both directories hit, or both miss, leave the selector unchanged. So do all training events for follower sets.
- R9: The selector saturates at 1023 and at 0 and never wraps.
- R10: A response is presented in the cycle after its request is accepted. While `rsp_ready` is low it stays valid and unchanged, and `req_ready` stays low.
- R11: While reset is asserted and right after it, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Victim request present |
| req_ready | output | 1 | Block can accept a request |
| req_set | input | 10 | Set index of the request |
| req_recency | input | 64 | Per-way 4-bit recency, 0 = least recent |
| req_cost | input | 48 | Per-way 3-bit quantized miss cost |
| rsp_valid | output | 1 | Victim answer present |
| rsp_ready | input | 1 | Consumer takes the answer |
| rsp_way | output | 4 | Chosen victim way |
| rsp_policy | output | 1 | 1 = cost-aware ranking, 0 = LRU |
| trn_valid | input | 1 | Training outcome present this cycle |
| trn_set | input | 10 | Set index of the outcome |
| trn_main_hit | input | 1 | Access hit in the main directory |
| trn_aux_hit | input | 1 | Access hit in the auxiliary LRU directory |
| trn_cost | input | 3 | Quantized cost of the miss |

## Verification
The selector counter cannot be read at the ports. Its state shows up only as the policy reported for follower sets. A wrong step size, a missing saturation or a wrap therefore becomes visible on the first follower request made after the counter would cross the value 512, and no earlier. The bench drives the counter to exact distances from that threshold, so that an error of a single unit flips the reported policy. A wrong score or tie rule shows up directly in `rsp_way` on the response that follows the request by one cycle.

// File: rtl/sbar_pkg.sv
package sbar_pkg;
  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_COST = 1'b1
  } policy_e;
endpackage

// File: rtl/sbar_leader_match.sv
module sbar_leader_match #(
  parameter int SET_W  = 10,
  parameter int LEAD_W = 5
) (
  input  logic [SET_W-1:0] set_idx,
  output logic             is_leader
);
  localparam int HI_LSB = SET_W - LEAD_W;

  // A set leads when its top field mirrors its bottom field.
  assign is_leader = (set_idx[SET_W-1:HI_LSB] == set_idx[LEAD_W-1:0]);
endmodule

// File: rtl/sbar_policy_counter.sv
module sbar_policy_counter #(
  parameter int CNT_W  = 10,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_en,
  input  logic              down_en,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W:0]   TOP_WIDE = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] MID      = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W:0]   step_wide;
  logic [CNT_W:0]   sum_wide;
  logic [CNT_W-1:0] count_nxt;

  assign step_wide = {{(CNT_W+1-STEP_W){1'b0}}, step};
  assign sum_wide  = {1'b0, count} + step_wide;

  always_comb begin
    count_nxt = count;
    if (up_en && !down_en) begin
      if (sum_wide > TOP_WIDE) count_nxt = TOP_WIDE[CNT_W-1:0];
      else                     count_nxt = sum_wide[CNT_W-1:0];
    end else if (down_en && !up_en) begin
      if ({1'b0, count} < step_wide) count_nxt = '0;
      else                           count_nxt = count - step_wide[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= MID;
    else        count <= count_nxt;
  end

  assert_up_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !down_en) |=> (count >= $past(count)));

  assert_down_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (down_en && !up_en) |=> (count <= $past(count)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_en && !down_en) |=> $stable(count));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !down_en && (&count)) |=> (&count));
endmodule

// File: rtl/sbar_victim_pick.sv
module sbar_victim_pick #(
  parameter int WAYS   = 16,
  parameter int REC_W  = 4,
  parameter int COST_W = 3,
  parameter int WEIGHT = 2,
  parameter int WAY_W  = 4
) (
  input  logic [WAYS*REC_W-1:0]  recency,
  input  logic [WAYS*COST_W-1:0] cost,
  input  logic                   use_cost,
  output logic [WAY_W-1:0]       victim
);
  localparam int SCORE_W = REC_W + COST_W + $clog2(WEIGHT + 1) + 1;

  logic [SCORE_W-1:0] score [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_score
    logic [SCORE_W-1:0] rec_ext;
    logic [SCORE_W-1:0] pen;
    assign rec_ext = SCORE_W'(recency[g*REC_W +: REC_W]);
    assign pen     = use_cost ? SCORE_W'(WEIGHT) * SCORE_W'(cost[g*COST_W +: COST_W])
                              : '0;
    assign score[g] = rec_ext + pen;
  end

  // Strict compare keeps the earliest way on equal scores.
  always_comb begin
    logic [SCORE_W-1:0] best;
    best   = score[0];
    victim = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (score[w] < best) begin
        best   = score[w];
        victim = WAY_W'(w);
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      assert_victim_minimal_R2: assert (!(score[w] < score[victim]));
      if (w < int'(victim)) begin
        assert_tie_lowest_R1: assert (score[w] != score[victim]);
      end
    end
  end
endmodule

// File: rtl/sbar_selector.sv
module sbar_selector #(
  parameter int WAYS   = 16,
  parameter int SET_W  = 10,
  parameter int LEAD_W = 5,
  parameter int COST_W = 3,
  parameter int CNT_W  = 10,
  parameter int WEIGHT = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [SET_W-1:0]                req_set,
  input  logic [WAYS*$clog2(WAYS)-1:0]    req_recency,
  input  logic [WAYS*COST_W-1:0]          req_cost,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [$clog2(WAYS)-1:0]         rsp_way,
  output logic                            rsp_policy,
  input  logic                            trn_valid,
  input  logic [SET_W-1:0]                trn_set,
  input  logic                            trn_main_hit,
  input  logic                            trn_aux_hit,
  input  logic [COST_W-1:0]               trn_cost
);
  import sbar_pkg::*;

  localparam int WAY_W = $clog2(WAYS);
  localparam int REC_W = $clog2(WAYS);

  logic             req_leader;
  logic             trn_leader;
  logic             sel_up;
  logic             sel_down;
  logic [CNT_W-1:0] sel_count;
  policy_e          pick_policy;
  logic [WAY_W-1:0] pick_way;
  logic             req_fire;

  sbar_leader_match #(.SET_W(SET_W), .LEAD_W(LEAD_W)) u_req_lead (
    .set_idx   (req_set),
    .is_leader (req_leader)
  );

  sbar_leader_match #(.SET_W(SET_W), .LEAD_W(LEAD_W)) u_trn_lead (
    .set_idx   (trn_set),
    .is_leader (trn_leader)
  );

  // Only disagreements between the two directories on a leader set train.
  assign sel_up   = trn_valid && trn_leader && trn_main_hit && !trn_aux_hit;
  assign sel_down = trn_valid && trn_leader && !trn_main_hit && trn_aux_hit;

  sbar_policy_counter #(.CNT_W(CNT_W), .STEP_W(COST_W)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_en   (sel_up),
    .down_en (sel_down),
    .step    (trn_cost),
    .count   (sel_count)
  );

  assign pick_policy = (req_leader || sel_count[CNT_W-1]) ? POL_COST : POL_LRU;

  sbar_victim_pick #(
    .WAYS(WAYS), .REC_W(REC_W), .COST_W(COST_W), .WEIGHT(WEIGHT), .WAY_W(WAY_W)
  ) u_pick (
    .recency  (req_recency),
    .cost     (req_cost),
    .use_cost (pick_policy == POL_COST),
    .victim   (pick_way)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_way    <= '0;
      rsp_policy <= 1'b0;
    end else if (req_fire) begin
      rsp_valid  <= 1'b1;
      rsp_way    <= pick_way;
      rsp_policy <= pick_policy;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_way) && $stable(rsp_policy)));

  assert_leader_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_leader) |=> (rsp_valid && rsp_policy));

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: tb/tb_sbar_selector.sv
module tb_sbar_selector;
  localparam int WAYS = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [9:0]  req_set;
  logic [63:0] req_recency;
  logic [47:0] req_cost;
  logic        rsp_valid, rsp_ready;
  logic [3:0]  rsp_way;
  logic        rsp_policy;
  logic        trn_valid;
  logic [9:0]  trn_set;
  logic        trn_main_hit, trn_aux_hit;
  logic [2:0]  trn_cost;

  int total = 0;
  int failed = 0;
  int rec_a  [WAYS];
  int cost_a [WAYS];

  localparam logic [9:0] LEAD_SET   = 10'h021;
  localparam logic [9:0] LEAD_SET2  = 10'h3FF;
  localparam logic [9:0] FOLLOW_SET = 10'h001;
  localparam logic [9:0] FOLLOW2    = 10'h3E0;

  always #5 clk = ~clk;

  sbar_selector dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_recency(req_recency), .req_cost(req_cost),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_way(rsp_way),
    .rsp_policy(rsp_policy), .trn_valid(trn_valid), .trn_set(trn_set),
    .trn_main_hit(trn_main_hit), .trn_aux_hit(trn_aux_hit), .trn_cost(trn_cost)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_way(bit lin);
    int best = 1000;
    int way = 0;
    for (int w = 0; w < WAYS; w++) begin
      int s = rec_a[w] + (lin ? 2 * cost_a[w] : 0);
      if (s < best) begin best = s; way = w; end
    end
    return way;
  endfunction

  function automatic void pack_vectors();
    for (int w = 0; w < WAYS; w++) begin
      req_recency[w*4 +: 4] = 4'(rec_a[w]);
      req_cost[w*3 +: 3]    = 3'(cost_a[w]);
    end
  endfunction

  function automatic void pattern_base();
    for (int w = 0; w < WAYS; w++) begin
      rec_a[w]  = (w + 13) % 16;
      cost_a[w] = 0;
    end
    cost_a[3] = 7;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1; trn_valid = 1'b0;
    req_set = '0; req_recency = '0; req_cost = '0;
    trn_set = '0; trn_main_hit = 1'b0; trn_aux_hit = 1'b0; trn_cost = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic request(logic [9:0] s, string tag, int exp_way, int exp_pol);
    @(negedge clk);
    req_set = s;
    pack_vectors();
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " way"}, int'(rsp_way), exp_way);
    chk({tag, " policy"}, int'(rsp_policy), exp_pol);
  endtask

  task automatic train(logic [9:0] s, bit mh, bit ah, int c, int n);
    @(negedge clk);
    trn_set = s; trn_main_hit = mh; trn_aux_hit = ah; trn_cost = 3'(c);
    trn_valid = 1'b1;
    repeat (n) @(negedge clk);
    trn_valid = 1'b0;
  endtask

  task automatic follower_policy(string tag, int exp_pol);
    pattern_base();
    request(FOLLOW_SET, tag, model_way(exp_pol == 1), exp_pol);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R11 req_ready after reset", int'(req_ready), 1);
  endtask

  task automatic t_lru_pick();
    do_reset();
    train(LEAD_SET, 1'b0, 1'b1, 1, 1);
    pattern_base();
    request(FOLLOW_SET, "R1 lru min recency", 3, 0);
    for (int w = 0; w < WAYS; w++) rec_a[w] = 8;
    rec_a[11] = 0; rec_a[6] = 0;
    request(FOLLOW_SET, "R1 lru tie lowest", 6, 0);
  endtask

  task automatic t_cost_pick();
    do_reset();
    pattern_base();
    request(FOLLOW_SET, "R2 cost score", 4, 1);
    pattern_base();
    cost_a[3] = 2; cost_a[4] = 1; cost_a[5] = 1;
    request(FOLLOW_SET, "R2 cost tie lowest", 4, 1);
    for (int w = 0; w < WAYS; w++) cost_a[w] = 7;
    cost_a[15] = 0;
    request(FOLLOW_SET, "R2 cost heavy", model_way(1'b1), 1);
  endtask

  task automatic t_leader();
    do_reset();
    train(LEAD_SET, 1'b0, 1'b1, 1, 1);
    pattern_base();
    request(LEAD_SET,  "R4 leader forced cost", 4, 1);
    request(LEAD_SET2, "R3 all-ones index leads", 4, 1);
    request(FOLLOW2,   "R3 mismatched index follows", 3, 0);
  endtask

  task automatic t_inc_dec();
    do_reset();
    follower_policy("R5 reset midpoint cost", 1);
    train(LEAD_SET, 1'b0, 1'b1, 1, 1);
    follower_policy("R7 down by one crosses", 0);
    train(LEAD_SET, 1'b1, 1'b0, 1, 1);
    follower_policy("R6 up by one returns", 1);
    train(LEAD_SET, 1'b1, 1'b0, 5, 1);
    train(LEAD_SET, 1'b0, 1'b1, 5, 1);
    follower_policy("R6 up by cost 5 then down 5", 1);
    train(LEAD_SET, 1'b0, 1'b1, 1, 1);
    follower_policy("R7 exact return below", 0);
  endtask

  task automatic t_nochange();
    do_reset();
    train(LEAD_SET, 1'b0, 1'b0, 7, 3);
    follower_policy("R8 both miss no down", 1);
    train(FOLLOW_SET, 1'b0, 1'b1, 7, 3);
    follower_policy("R8 follower training ignored", 1);
    train(LEAD_SET, 1'b0, 1'b1, 1, 1);
    train(LEAD_SET, 1'b1, 1'b1, 7, 3);
    follower_policy("R8 both hit no up", 0);
  endtask

  task automatic t_saturate();
    do_reset();
    train(LEAD_SET, 1'b1, 1'b0, 7, 200);
    train(LEAD_SET, 1'b0, 1'b1, 1, 511);
    follower_policy("R9 top saturate 512 left", 1);
    train(LEAD_SET, 1'b0, 1'b1, 1, 1);
    follower_policy("R9 top saturate 511 left", 0);
    train(LEAD_SET, 1'b0, 1'b1, 7, 200);
    train(LEAD_SET, 1'b1, 1'b0, 1, 511);
    follower_policy("R9 bottom saturate at 511", 0);
    train(LEAD_SET, 1'b1, 1'b0, 1, 1);
    follower_policy("R9 bottom saturate at 512", 1);
  endtask

  task automatic t_backpressure();
    do_reset();
    pattern_base();
    rsp_ready = 1'b0;
    @(negedge clk);
    req_set = FOLLOW_SET; pack_vectors(); req_valid = 1'b1;
    @(negedge clk);
    req_set = LEAD_SET;
    for (int w = 0; w < WAYS; w++) rec_a[w] = 15 - w;
    pack_vectors();
    chk("R10 first rsp valid", int'(rsp_valid), 1);
    chk("R10 req_ready low when full", int'(req_ready), 0);
    chk("R10 first rsp way", int'(rsp_way), 4);
    @(negedge clk);
    chk("R10 held rsp way", int'(rsp_way), 4);
    chk("R10 held rsp valid", int'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second rsp valid", int'(rsp_valid), 1);
    chk("R10 second rsp way", int'(rsp_way), 15);
    chk("R10 second rsp policy", int'(rsp_policy), 1);
    @(negedge clk);
    chk("R10 drained", int'(rsp_valid), 0);
  endtask

  initial begin
    t_reset();
    t_lru_pick();
    t_cost_pick();
    t_leader();
    t_inc_dec();
    t_nochange();
    t_saturate();
    t_backpressure();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule